// File: doc/BRIEF.md
# Gated Clock Fan-Out with Pin and Register Enables

This block takes one free-running clock and produces nine gated copies of it. Each copy runs only while two conditions hold together: its hardware enable pin is high and its software control bit is high. Some pins are private to one output and others are shared by a group. The software bits sit in two byte-wide control registers. A plain synchronous port writes them and a combinational port reads them back; this port stands in for a serial management bus.

Enable changes may arrive at any time. A disabled output completes the high pulse already in progress and then stays low. A re-enabled output starts again on a clock edge with a full-width pulse. Hardware pins are synchronized to the clock first. Each output's enable is then captured during the low phase of the clock, in the style of a latch-based clock gate.

Top module: `clk_gate_bank`

## Requirements
- R1: While enabled, clk_o[i] equals clk_i with full high and low phases. Every output is low whenever clk_i is low.
- R2: An output runs only when its synchronized pin AND its register bit are both 1. Either one at 0 stops it.
- R3: Pin mapping: hw_en_i[0..3] drive outputs 0..3 one to one; hw_en_i[4] drives outputs 4 and 5; hw_en_i[5] drives outputs 6, 7 and 8.
- R4: Register bit mapping, with control byte index 1 = A and index 2 = B: out0 A[4], out1 A[2], out2 B[1], out3 B[0], out4 A[7], out5 A[6], out6 B[5], out7 B[4], out8 B[3].
- R5: Reset sets both control bytes to 0xFF, and all nine outputs run.
- R6: A register write that clears a bit is sampled at edge k. The pulse that starts at edge k still completes. From edge k+1 on, the output stays low.
- R7: A register write that sets a bit is sampled at edge k. The first new pulse starts at edge k+1 and has full width.
- R8: A pin level sampled at edge k first affects the output in the high phase that starts at edge k+2. This follows from a two-stage synchronizer.
- R9: Control bits not named in R4 can be written and read back, and have no effect on any output.
- R10: Writes to byte indices other than 1 and 2 change nothing. Reads of those indices return 0x00.
- R11: rd_data_o returns the control byte selected by byte_idx_i without delay. A byte written at an edge reads back from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hw_en_i | input | 6 | Asynchronous hardware enable pins |
| wr_en_i | input | 1 | Register write strobe |
| byte_idx_i | input | 2 | Control byte index for write and read |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data of the selected byte |
| clk_o | output | 9 | Gated clock outputs |

## Verification
Suppose a captured enable is wrong, or a mapping entry points at the wrong pin or bit. The affected output then runs or stays silent in the very next high phase after the change. For that reason, every output is toggled on its own, both from the register side and from the pin side. A latch that opens in the wrong phase would show up as a shortened pulse, or as a level during the low phase of clk_i, within one cycle. The stop and restart edges are therefore sampled cycle by cycle, at the start and at the end of each high phase. If the synchronizer depth is wrong, the pin response moves by one edge away from the edge given in R8.

// File: rtl/cg_pkg.sv
package cg_pkg;
  localparam int NUM_OUT = 9;
  localparam int NUM_PIN = 6;
  localparam int DATA_W  = 8;
  localparam int IDX_W   = 2;
  // per-output pin, byte index and bit position
  localparam int OUT_PIN  [NUM_OUT] = '{0, 1, 2, 3, 4, 4, 5, 5, 5};
  localparam int OUT_BYTE [NUM_OUT] = '{1, 1, 2, 2, 1, 1, 2, 2, 2};
  localparam int OUT_BIT  [NUM_OUT] = '{4, 2, 1, 0, 7, 6, 5, 4, 3};
endpackage

// File: rtl/cg_pin_sync.sv
module cg_pin_sync #(
  parameter int   WIDTH  = 6,
  parameter int   STAGES = 2,
  parameter logic RST_V  = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= {WIDTH{RST_V}};
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cg_ctrl_regs.sv
module cg_ctrl_regs #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] byte_a_o,
  output logic [DATA_W-1:0] byte_b_o
);
  localparam logic [IDX_W-1:0] IDX_A = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_B = IDX_W'(2);

  logic [DATA_W-1:0] byte_a_q, byte_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_a_q <= '1;
      byte_b_q <= '1;
    end else if (wr_en_i) begin
      if (idx_i == IDX_A) byte_a_q <= wr_data_i;
      if (idx_i == IDX_B) byte_b_q <= wr_data_i;
    end
  end

  always_comb begin
    unique case (idx_i)
      IDX_A:   rd_data_o = byte_a_q;
      IDX_B:   rd_data_o = byte_b_q;
      default: rd_data_o = '0;
    endcase
  end

  assign byte_a_o = byte_a_q;
  assign byte_b_o = byte_b_q;
endmodule

// File: rtl/cg_clk_gate.sv
module cg_clk_gate (
  input  logic clk_i,
  input  logic en_i,
  output logic clk_o
);
  logic en_l;

  // transparent in low phase only
  always_latch begin
    if (!clk_i) en_l <= en_i;
  end

  assign clk_o = clk_i & en_l;
endmodule

// File: rtl/clk_gate_bank.sv
module clk_gate_bank
  import cg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_PIN-1:0] hw_en_i,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   byte_idx_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic [NUM_OUT-1:0] clk_o
);
  logic [NUM_PIN-1:0] pin_s;
  logic [DATA_W-1:0]  ctrl_a, ctrl_b;
  logic [NUM_OUT-1:0] gate_en;

  cg_pin_sync #(
    .WIDTH (NUM_PIN),
    .STAGES(SYNC_STAGES),
    .RST_V (1'b1)
  ) i_pin_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (hw_en_i),
    .q_o   (pin_s)
  );

  cg_ctrl_regs #(
    .DATA_W(DATA_W),
    .IDX_W (IDX_W)
  ) i_ctrl_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .idx_i    (byte_idx_i),
    .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o),
    .byte_a_o (ctrl_a),
    .byte_b_o (ctrl_b)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    if (OUT_BYTE[g] == 1) begin : g_a
      assign gate_en[g] = pin_s[OUT_PIN[g]] & ctrl_a[OUT_BIT[g]];
    end else begin : g_b
      assign gate_en[g] = pin_s[OUT_PIN[g]] & ctrl_b[OUT_BIT[g]];
    end

    cg_clk_gate i_gate (
      .clk_i(clk_i),
      .en_i (gate_en[g]),
      .clk_o(clk_o[g])
    );
  end
endmodule

// File: rtl/cg_chk.sv
module cg_chk
  import cg_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_OUT-1:0] clk_o,
  input logic [NUM_PIN-1:0] pin_s,
  input logic [DATA_W-1:0]  ctrl_a,
  input logic [DATA_W-1:0]  ctrl_b,
  input logic               wr_en_i,
  input logic [IDX_W-1:0]   byte_idx_i,
  input logic [DATA_W-1:0]  wr_data_i,
  input logic [DATA_W-1:0]  rd_data_o
);
  // R1
  low_phase_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_o == '0);

  // R4
  out0_bit_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    clk_o[0] |-> $past(ctrl_a[4]));
  // R4
  out8_bit_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    clk_o[8] |-> $past(ctrl_b[3]));
  // R3
  grp45_pin_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (clk_o[4] | clk_o[5]) |-> $past(pin_s[4]));
  // R3
  grp678_pin_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (clk_o[6] | clk_o[7] | clk_o[8]) |-> $past(pin_s[5]));

  // R10
  bad_idx_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && byte_idx_i != IDX_W'(1) && byte_idx_i != IDX_W'(2))
    |=> $stable({ctrl_a, ctrl_b}));

  // R11
  readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_idx_i == IDX_W'(1) && $past(wr_en_i && byte_idx_i == IDX_W'(1)))
    |-> rd_data_o == $past(wr_data_i));
endmodule

bind clk_gate_bank cg_chk i_cg_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clk_o     (clk_o),
  .pin_s     (pin_s),
  .ctrl_a    (ctrl_a),
  .ctrl_b    (ctrl_b),
  .wr_en_i   (wr_en_i),
  .byte_idx_i(byte_idx_i),
  .wr_data_i (wr_data_i),
  .rd_data_o (rd_data_o)
);

// File: tb/test_clk_gate_bank.sv
module test_clk_gate_bank;
  localparam int PMAP [9] = '{0, 1, 2, 3, 4, 4, 5, 5, 5};
  localparam int BMAP [9] = '{1, 1, 2, 2, 1, 1, 2, 2, 2};
  localparam int TMAP [9] = '{4, 2, 1, 0, 7, 6, 5, 4, 3};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] hw_en = 6'h3f;
  logic       wr_en = 1'b0;
  logic [1:0] idx = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [8:0] clk_out;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_a = 8'hff, m_b = 8'hff;

  always #10 clk = ~clk;

  clk_gate_bank i_clk_gate_bank (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .hw_en_i   (hw_en),
    .wr_en_i   (wr_en),
    .byte_idx_i(idx),
    .wr_data_i (wdata),
    .rd_data_o (rdata),
    .clk_o     (clk_out)
  );

  function automatic logic [8:0] exp_mask();
    logic [8:0] m;
    for (int i = 0; i < 9; i++)
      m[i] = hw_en[PMAP[i]] & (BMAP[i] == 1 ? m_a[TMAP[i]] : m_b[TMAP[i]]);
    return m;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] i, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; idx = i; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (i == 2'd1) m_a = d;
    if (i == 2'd2) m_b = d;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] i, input logic [7:0] e);
    @(negedge clk);
    idx = i;
    #2 chk(tag, rdata, e);
  endtask

  // settle, then sample start/end of high phase and the low phase
  task automatic run_chk(input string tag);
    repeat (4) @(negedge clk);
    @(posedge clk); #2 chk({tag, " hi-start"}, clk_out, exp_mask());
    #6 chk({tag, " hi-end"}, clk_out, exp_mask());
    @(negedge clk); #5 chk({tag, " lo"}, clk_out, 9'h000);
  endtask

  task automatic t_reset;
    rd_chk("R5 byte A", 2'd1, 8'hff);
    rd_chk("R5 byte B", 2'd2, 8'hff);
    run_chk("R5 R1 all run");
  endtask

  task automatic t_reg_walk;
    for (int i = 0; i < 9; i++) begin
      wr(BMAP[i][1:0], ~(8'h01 << TMAP[i]));
      run_chk($sformatf("R4 R2 out%0d reg off", i));
      wr(BMAP[i][1:0], 8'hff);
    end
    run_chk("R4 restored");
  endtask

  task automatic t_pin_walk;
    for (int p = 0; p < 6; p++) begin
      @(negedge clk); hw_en = ~(6'h01 << p);
      run_chk($sformatf("R3 R2 pin%0d off", p));
      @(negedge clk); hw_en = 6'h3f;
    end
    // AND: pin low with bit low, and pin high with bit low
    wr(2'd1, 8'hef);
    @(negedge clk); hw_en = 6'h3e;
    run_chk("R2 both low");
    @(negedge clk); hw_en = 6'h3f;
    run_chk("R2 pin high bit low");
    wr(2'd1, 8'hff);
    run_chk("R2 both high");
  endtask

  task automatic t_unmapped;
    wr(2'd1, 8'hd4);
    wr(2'd2, 8'h3f);
    rd_chk("R9 read A", 2'd1, 8'hd4);
    rd_chk("R9 read B", 2'd2, 8'h3f);
    run_chk("R9 unmapped cleared");
    wr(2'd2, 8'hc0);
    run_chk("R9 B mapped cleared");
    rd_chk("R11 read B", 2'd2, 8'hc0);
    wr(2'd1, 8'hff);
    wr(2'd2, 8'hff);
  endtask

  task automatic t_bad_idx;
    wr(2'd0, 8'h00);
    wr(2'd3, 8'h00);
    m_a = 8'hff; m_b = 8'hff;
    rd_chk("R10 A kept", 2'd1, 8'hff);
    rd_chk("R10 B kept", 2'd2, 8'hff);
    rd_chk("R10 idx0 reads 0", 2'd0, 8'h00);
    rd_chk("R10 idx3 reads 0", 2'd3, 8'h00);
    run_chk("R10 outputs kept");
  endtask

  task automatic t_reg_latency;
    @(negedge clk);
    wr_en = 1'b1; idx = 2'd1; wdata = 8'hef;
    @(posedge clk); #2 chk("R6 pulse k start", clk_out[0], 1'b1);
    #6 chk("R6 pulse k full", clk_out[0], 1'b1);
    @(negedge clk); wr_en = 1'b0;
    @(posedge clk); #2 chk("R6 off at k+1", clk_out[0], 1'b0);
    @(negedge clk); #5 chk("R6 parked low", clk_out[0], 1'b0);
    wr_en = 1'b1; wdata = 8'hff;
    @(posedge clk); #2 chk("R7 still off at k", clk_out[0], 1'b0);
    @(negedge clk); wr_en = 1'b0;
    @(posedge clk); #2 chk("R7 on at k+1", clk_out[0], 1'b1);
    #6 chk("R7 full width", clk_out[0], 1'b1);
    m_a = 8'hff;
  endtask

  task automatic t_pin_latency;
    @(negedge clk); hw_en[4] = 1'b0;
    @(posedge clk); #2 chk("R8 edge k runs", clk_out[5:4], 2'b11);
    @(posedge clk); #2 chk("R8 edge k+1 runs", clk_out[5:4], 2'b11);
    @(posedge clk); #2 chk("R8 edge k+2 off", clk_out[5:4], 2'b00);
    @(negedge clk); hw_en[4] = 1'b1;
    @(posedge clk); #2 chk("R8 re-en k off", clk_out[5:4], 2'b00);
    @(posedge clk); #2 chk("R8 re-en k+1 off", clk_out[5:4], 2'b00);
    @(posedge clk); #2 chk("R8 re-en k+2 on", clk_out[5:4], 2'b11);
    #6 chk("R8 re-en full width", clk_out[5:4], 2'b11);
  endtask

  task automatic t_reset_again;
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h00);
    run_chk("R2 all off");
    @(negedge clk); rst_n = 1'b0;
    m_a = 8'hff; m_b = 8'hff;
    rd_chk("R5 A in reset", 2'd1, 8'hff);
    @(negedge clk); rst_n = 1'b1;
    rd_chk("R5 B after reset", 2'd2, 8'hff);
    run_chk("R5 all run after reset");
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_reg_walk();
    t_pin_walk();
    t_unmapped();
    t_bad_idx();
    t_reg_latency();
    t_pin_latency();
    t_reset_again();
    finish_run();
  end

  initial begin
    #(20 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end
endmodule